// File: doc/BRIEF.md
# Delayed Read Transaction Tracker

This block keeps track of a single delayed read between a bus target and a backend master. Both sides run on the same clock. The target posts a read with its address, bus command, byte enables, direction flag and burst hint. The tracker stores these fields and offers them to the backend behind a valid flag. The backend takes the request with a one-cycle accept pulse.

Later, the backend reports the result with a completion strobe and a status bit. The status bit is only stored, because per-word data errors are judged elsewhere. The target keeps retrying the read. A retry proceeds only if both its address and its command equal the stored ones. Any other request is told to retry.

While the target delivers the completion, it holds an in-progress flag. When it finishes, it pulses done, which frees the tracker. If nobody claims a completion within a long timeout, the tracker drops it and pulses a flush to the read-data buffer.

Top module: `dly_read_tracker`

## Requirements
- R1: A target request (`tgt_req_i`) while no read is pending is captured at that clock edge. From the next cycle, `req_pend_o` and `bk_req_o` are 1, and `bk_addr_o`, `bk_cmd_o`, `bk_be_o` and `bk_we_o` (1 = write, 0 = read) carry the captured values.
- R2: `bk_burst_o` is 1 only when the captured request had `tgt_burst_i` = 1 and `tgt_pref_en_i` = 1.
- R3: An accept pulse on `bk_accept_i` clears `bk_req_o` from the next cycle. `req_pend_o` stays 1.
- R4: `same_read_o` is 1 exactly when a read is pending and both `tgt_addr_i` and `tgt_cmd_i` equal the stored address and command. A difference in either field alone gives 0.
- R5: `retry_o` is 1 for a target request made while a read is pending, unless it is a same read with the completion ready. A refused request leaves every stored field unchanged.
- R6: A completion strobe (`bk_comp_i`) while a read is pending sets `comp_pend_o` from the next cycle and records `bk_status_i` on `comp_status_o`. A strobe with nothing pending is ignored, and `comp_pend_o` stays 0.
- R7: `tgt_done_i` while `comp_pend_o` is 1 clears both `req_pend_o` and `comp_pend_o` from the next cycle, with no flush.
- R8: If neither done nor in-progress occurs, `comp_pend_o` stays 1 for exactly `TMO_CYCLES` cycles. It then drops, and `flush_o` is 1 for exactly one cycle, together with `req_pend_o` going to 0.
- R9: Cycles with `tgt_in_prog_i` = 1 do not advance the timeout. The completion is never flushed during delivery.
- R10: A synchronous active-high `rst` clears the pending flags, the valid flag, the stored fields, the status and the timeout count. All outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tgt_req_i | input | 1 | Target read request strobe |
| tgt_addr_i | input | AW | Target request address |
| tgt_cmd_i | input | CW | Target bus command |
| tgt_be_i | input | BW | Target byte enables |
| tgt_we_i | input | 1 | Direction, 1 = write |
| tgt_burst_i | input | 1 | Request is a burst read |
| tgt_pref_en_i | input | 1 | Prefetch enabled for the hit image |
| tgt_in_prog_i | input | 1 | Target is delivering the completion |
| tgt_done_i | input | 1 | Target finished the cycle on its bus |
| same_read_o | output | 1 | Current target read matches the stored one |
| retry_o | output | 1 | Current target request must be retried |
| bk_req_o | output | 1 | Backend request fields valid |
| bk_addr_o | output | AW | Stored address |
| bk_cmd_o | output | CW | Stored command |
| bk_be_o | output | BW | Stored byte enables |
| bk_we_o | output | 1 | Stored direction |
| bk_burst_o | output | 1 | Burst allowed |
| bk_accept_i | input | 1 | Backend takes the request |
| bk_comp_i | input | 1 | Backend completion strobe |
| bk_status_i | input | 1 | Completion error status |
| req_pend_o | output | 1 | Request pending |
| comp_pend_o | output | 1 | Completion ready for the target |
| comp_status_o | output | 1 | Recorded completion status |
| flush_o | output | 1 | One-cycle read-data flush pulse |

## Verification
The bench compares retried reads that differ only in address, only in command, or only in the lowest address bit. A tracker that compared a single field would let a foreign read take another master's data. It also sends a completion strobe while idle and a mismatched request while a read is pending. A tracker that wrongly took either one would show a phantom completion or overwritten fields. The timeout run counts the exact flush cycle and pauses it with in-progress near expiry, which exposes off-by-one counters and flushes during delivery.

// File: rtl/dly_read_pkg.sv
package dly_read_pkg;
  typedef struct packed {
    logic we;
    logic burst;
  } req_flags_t;
endpackage

// File: rtl/dr_req_store.sv
module dr_req_store #(
  parameter int AW = 32,
  parameter int CW = 4,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] cmd_i,
  input  logic [BW-1:0] be_i,
  input  dly_read_pkg::req_flags_t flags_i,
  input  logic [AW-1:0] cmp_addr_i,
  input  logic [CW-1:0] cmp_cmd_i,
  output logic          match_o,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] cmd_o,
  output logic [BW-1:0] be_o,
  output dly_read_pkg::req_flags_t flags_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o  <= '0;
      cmd_o   <= '0;
      be_o    <= '0;
      flags_o <= '0;
    end else if (load) begin
      addr_o  <= addr_i;
      cmd_o   <= cmd_i;
      be_o    <= be_i;
      flags_o <= flags_i;
    end
  end

  // both fields must agree for a retry to be the same read
  assign match_o = (cmp_addr_i == addr_o) && (cmp_cmd_i == cmd_o);
endmodule

// File: rtl/dr_comp_timer.sv
module dr_comp_timer #(
  parameter int TMO_CYCLES = 65536
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic expire_o
);
  localparam int CNT_W = (TMO_CYCLES > 1) ? $clog2(TMO_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || start) cnt_q <= '0;
    else if (run)     cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run && (cnt_q == LAST);
endmodule

// File: rtl/dly_read_tracker.sv
module dly_read_tracker #(
  parameter int AW = 32,
  parameter int CW = 4,
  parameter int BW = 4,
  parameter int TMO_CYCLES = 65536
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tgt_req_i,
  input  logic [AW-1:0] tgt_addr_i,
  input  logic [CW-1:0] tgt_cmd_i,
  input  logic [BW-1:0] tgt_be_i,
  input  logic          tgt_we_i,
  input  logic          tgt_burst_i,
  input  logic          tgt_pref_en_i,
  input  logic          tgt_in_prog_i,
  input  logic          tgt_done_i,
  output logic          same_read_o,
  output logic          retry_o,
  output logic          bk_req_o,
  output logic [AW-1:0] bk_addr_o,
  output logic [CW-1:0] bk_cmd_o,
  output logic [BW-1:0] bk_be_o,
  output logic          bk_we_o,
  output logic          bk_burst_o,
  input  logic          bk_accept_i,
  input  logic          bk_comp_i,
  input  logic          bk_status_i,
  output logic          req_pend_o,
  output logic          comp_pend_o,
  output logic          comp_status_o,
  output logic          flush_o
);
  import dly_read_pkg::*;

  logic req_pend_q, comp_pend_q, bk_req_q, status_q, flush_q;
  logic start_req, take_comp, done_hit, expire, match;
  req_flags_t in_flags, st_flags;

  assign start_req = tgt_req_i && !req_pend_q;
  assign take_comp = bk_comp_i && req_pend_q && !comp_pend_q;
  assign done_hit  = tgt_done_i && comp_pend_q;
  assign in_flags  = '{we: tgt_we_i, burst: tgt_burst_i && tgt_pref_en_i};

  dr_req_store #(.AW(AW), .CW(CW), .BW(BW)) u_store (
    .clk        (clk),
    .rst        (rst),
    .load       (start_req),
    .addr_i     (tgt_addr_i),
    .cmd_i      (tgt_cmd_i),
    .be_i       (tgt_be_i),
    .flags_i    (in_flags),
    .cmp_addr_i (tgt_addr_i),
    .cmp_cmd_i  (tgt_cmd_i),
    .match_o    (match),
    .addr_o     (bk_addr_o),
    .cmd_o      (bk_cmd_o),
    .be_o       (bk_be_o),
    .flags_o    (st_flags)
  );

  dr_comp_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start    (take_comp),
    .run      (comp_pend_q && !tgt_in_prog_i),
    .expire_o (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_pend_q  <= 1'b0;
      comp_pend_q <= 1'b0;
      bk_req_q    <= 1'b0;
      status_q    <= 1'b0;
      flush_q     <= 1'b0;
    end else begin
      flush_q <= expire && !done_hit;
      if (done_hit || expire) begin
        req_pend_q  <= 1'b0;
        comp_pend_q <= 1'b0;
        bk_req_q    <= 1'b0;
      end else begin
        if (start_req) begin
          req_pend_q <= 1'b1;
          bk_req_q   <= 1'b1;
        end else if (bk_accept_i) begin
          bk_req_q <= 1'b0;
        end
        if (take_comp) begin
          comp_pend_q <= 1'b1;
          status_q    <= bk_status_i;
        end
      end
    end
  end

  assign same_read_o   = req_pend_q && match;
  assign retry_o       = tgt_req_i && req_pend_q && !(match && comp_pend_q);
  assign bk_req_o      = bk_req_q;
  assign bk_we_o       = st_flags.we;
  assign bk_burst_o    = st_flags.burst;
  assign req_pend_o    = req_pend_q;
  assign comp_pend_o   = comp_pend_q;
  assign comp_status_o = status_q;
  assign flush_o       = flush_q;
endmodule

// File: rtl/dly_read_tracker_chk.sv
module dly_read_tracker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          tgt_req_i,
  input logic          tgt_in_prog_i,
  input logic          tgt_done_i,
  input logic          bk_comp_i,
  input logic          req_pend_o,
  input logic          comp_pend_o,
  input logic          flush_o,
  input logic [AW-1:0] bk_addr_o
);
  // R6
  comp_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    comp_pend_o |-> req_pend_o);

  // R6
  idle_comp_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_pend_o && bk_comp_i) |=> !comp_pend_o);

  // R5
  refused_req_keeps_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (req_pend_o && tgt_req_i && !tgt_done_i) |=> $stable(bk_addr_o));

  // R7
  done_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt_done_i && comp_pend_o) |=> (!req_pend_o && !comp_pend_o && !flush_o));

  // R8
  flush_single_chk: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> !flush_o);

  // R8
  flush_follows_comp_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flush_o) |-> ($fell(comp_pend_o) && !req_pend_o));

  // R9
  in_prog_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (comp_pend_o && tgt_in_prog_i && !tgt_done_i) |=> comp_pend_o);
endmodule

bind dly_read_tracker dly_read_tracker_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .tgt_req_i     (tgt_req_i),
  .tgt_in_prog_i (tgt_in_prog_i),
  .tgt_done_i    (tgt_done_i),
  .bk_comp_i     (bk_comp_i),
  .req_pend_o    (req_pend_o),
  .comp_pend_o   (comp_pend_o),
  .flush_o       (flush_o),
  .bk_addr_o     (bk_addr_o)
);

// File: tb/dly_read_tracker_bench.sv
module dly_read_tracker_bench;
  localparam int AW = 32, CW = 4, BW = 4, TMO = 65536;

  logic clk = 1'b0, rst = 1'b1;
  logic tgt_req_i = 0, tgt_we_i = 0, tgt_burst_i = 0, tgt_pref_en_i = 0;
  logic tgt_in_prog_i = 0, tgt_done_i = 0;
  logic [AW-1:0] tgt_addr_i = '0;
  logic [CW-1:0] tgt_cmd_i = '0;
  logic [BW-1:0] tgt_be_i = '0;
  logic bk_accept_i = 0, bk_comp_i = 0, bk_status_i = 0;
  logic same_read_o, retry_o, bk_req_o, bk_we_o, bk_burst_o;
  logic [AW-1:0] bk_addr_o;
  logic [CW-1:0] bk_cmd_o;
  logic [BW-1:0] bk_be_o;
  logic req_pend_o, comp_pend_o, comp_status_o, flush_o;

  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  dly_read_tracker #(.AW(AW), .CW(CW), .BW(BW), .TMO_CYCLES(TMO)) u_dly_read_tracker (
    .clk(clk), .rst(rst), .tgt_req_i(tgt_req_i), .tgt_addr_i(tgt_addr_i),
    .tgt_cmd_i(tgt_cmd_i), .tgt_be_i(tgt_be_i), .tgt_we_i(tgt_we_i),
    .tgt_burst_i(tgt_burst_i), .tgt_pref_en_i(tgt_pref_en_i),
    .tgt_in_prog_i(tgt_in_prog_i), .tgt_done_i(tgt_done_i),
    .same_read_o(same_read_o), .retry_o(retry_o), .bk_req_o(bk_req_o),
    .bk_addr_o(bk_addr_o), .bk_cmd_o(bk_cmd_o), .bk_be_o(bk_be_o),
    .bk_we_o(bk_we_o), .bk_burst_o(bk_burst_o), .bk_accept_i(bk_accept_i),
    .bk_comp_i(bk_comp_i), .bk_status_i(bk_status_i), .req_pend_o(req_pend_o),
    .comp_pend_o(comp_pend_o), .comp_status_o(comp_status_o), .flush_o(flush_o)
  );

  // {address, command, expected same_read} with stored 0x1000_0040 / 0x6
  localparam logic [AW+CW:0] SAME_VEC [5] = '{
    {32'h1000_0040, 4'h6, 1'b1},
    {32'h1000_0044, 4'h6, 1'b0},
    {32'h1000_0040, 4'hC, 1'b0},
    {32'h2000_0000, 4'hE, 1'b0},
    {32'h1000_0041, 4'h6, 1'b0}
  };

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(); step();
    rst = 0;
    // R10: reset state
    chk("R10 req_pend", req_pend_o, 0);
    chk("R10 bk_req", bk_req_o, 0);
    chk("R10 addr", bk_addr_o, 0);

    // R1 / R2: capture
    tgt_req_i = 1; tgt_addr_i = 32'h1000_0040; tgt_cmd_i = 4'h6; tgt_be_i = 4'hA;
    tgt_we_i = 0; tgt_burst_i = 1; tgt_pref_en_i = 1;
    step();
    tgt_req_i = 0;
    chk("R1 req_pend", req_pend_o, 1);
    chk("R1 bk_req", bk_req_o, 1);
    chk("R1 addr", bk_addr_o, 32'h1000_0040);
    chk("R1 cmd", bk_cmd_o, 4'h6);
    chk("R1 be", bk_be_o, 4'hA);
    chk("R1 we", bk_we_o, 0);
    chk("R2 burst on", bk_burst_o, 1);

    // R3: accept
    bk_accept_i = 1; step(); bk_accept_i = 0;
    chk("R3 bk_req", bk_req_o, 0);
    chk("R3 req_pend", req_pend_o, 1);

    // R4: compare table
    foreach (SAME_VEC[i]) begin
      tgt_addr_i = SAME_VEC[i][AW+CW:CW+1];
      tgt_cmd_i  = SAME_VEC[i][CW:1];
      #1;
      chk("R4 same_read", same_read_o, SAME_VEC[i][0]);
    end

    // R5: foreign request refused
    tgt_req_i = 1; tgt_addr_i = 32'h3000_0000; tgt_cmd_i = 4'h7; #1;
    chk("R5 retry foreign", retry_o, 1);
    step(); tgt_req_i = 0;
    chk("R5 addr kept", bk_addr_o, 32'h1000_0040);
    chk("R5 cmd kept", bk_cmd_o, 4'h6);

    // R5: same read before completion still retried
    tgt_req_i = 1; tgt_addr_i = 32'h1000_0040; tgt_cmd_i = 4'h6; #1;
    chk("R5 retry early same", retry_o, 1);
    tgt_req_i = 0;

    // R6: completion
    bk_comp_i = 1; bk_status_i = 1; step(); bk_comp_i = 0; bk_status_i = 0;
    chk("R6 comp_pend", comp_pend_o, 1);
    chk("R6 status", comp_status_o, 1);
    tgt_req_i = 1; #1;
    chk("R5 same proceeds", retry_o, 0);
    tgt_req_i = 0;

    // R7: done
    tgt_in_prog_i = 1; step(); tgt_done_i = 1; step();
    tgt_done_i = 0; tgt_in_prog_i = 0;
    chk("R7 req_pend", req_pend_o, 0);
    chk("R7 comp_pend", comp_pend_o, 0);
    chk("R7 flush", flush_o, 0);
    chk("R4 idle same", same_read_o, 0);

    // R6: idle completion ignored
    bk_comp_i = 1; step(); bk_comp_i = 0;
    chk("R6 idle comp", comp_pend_o, 0);
    step();
    chk("R6 idle comp later", comp_pend_o, 0);

    // R2: burst without prefetch; then R10 mid-flight reset
    tgt_req_i = 1; tgt_addr_i = 32'h0000_0100; tgt_cmd_i = 4'hC; tgt_we_i = 1;
    tgt_burst_i = 1; tgt_pref_en_i = 0;
    step(); tgt_req_i = 0;
    chk("R2 burst off", bk_burst_o, 0);
    chk("R1 we set", bk_we_o, 1);
    rst = 1; step(); rst = 0;
    chk("R10 mid req_pend", req_pend_o, 0);
    chk("R10 mid cmd", bk_cmd_o, 0);

    // R8 / R9: timeout with in-progress pause
    tgt_req_i = 1; tgt_we_i = 0; step(); tgt_req_i = 0;
    bk_accept_i = 1; step(); bk_accept_i = 0;
    bk_comp_i = 1; step(); bk_comp_i = 0;
    repeat (TMO - 10) step();
    chk("R8 still pending", comp_pend_o, 1);
    tgt_in_prog_i = 1;
    repeat (20) step();
    tgt_in_prog_i = 0;
    chk("R9 held", comp_pend_o, 1);
    repeat (9) step();
    chk("R9 last cycle pending", comp_pend_o, 1);
    chk("R8 no early flush", flush_o, 0);
    step();
    chk("R8 comp dropped", comp_pend_o, 0);
    chk("R8 req dropped", req_pend_o, 0);
    chk("R8 flush", flush_o, 1);
    step();
    chk("R8 flush one cycle", flush_o, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule